// File: doc/BRIEF.md
# Recorder Key Conditioner

This block sits between the eight push-button inputs of a flash voice recorder and its control core. Each raw key is synchronised and debounced. Each key is then turned into the form the core acts on. Record and level-play become clean levels that stay high while the key is held. Edge-play, stop and erase become one-cycle strobes. Forward, backward and reset are timed, so a brief press and a long hold give different commands.

The core reports its current activity (idle, recording, playing, erasing), and the block gates every key against that state. Stop is honoured only during playback. Only reset gets through while an erase runs. A low-battery comparator bit is checked at the moment a record, erase or reset command would be issued. When the battery is low, the command is dropped and a two-second 3 Hz blink request starts on the LED output. All time constants are given in milliseconds and converted to clock cycles from the clock-frequency parameter.

Top module: `key_cmd_conditioner`

## Requirements
- R1: A raw key change is accepted only after the synchronised input has differed from the accepted level for DEB_MS worth of consecutive cycles. A shorter pulse produces no output.
- R2: Key index 0 (record) and key index 1 (level-play) drive `rec_level` and `lplay_level` high while the debounced key is held, and low after its release.
- R3: Key index 2 (edge-play) and key index 4 (erase) each produce exactly one strobe per debounced press.
- R4: Key index 5 (forward) and key index 6 (backward), released before FB_LONG_MS of debounced hold, give one `fwd_stb` / `bwd_stb` on release.
- R5: Forward or backward held for FB_LONG_MS gives one `fwd_long_stb` / `bwd_long_stb` while still held, and no short strobe on release.
- R6: Key index 7 (reset), released before RST_LONG_MS, gives one `init_stb`. Held for RST_LONG_MS, it gives one `chip_erase_stb` while still held and nothing on release.
- R7: Key index 3 (stop) gives `stop_stb` only when `core_state` is 2 (playing). In any other state it has no effect.
- R8: While `core_state` is 3 (erasing), every key except reset is ignored: no strobe is issued and `rec_level` and `lplay_level` stay low.
- R9: If `batt_low` is high when a record press, an erase strobe or a reset strobe would be issued, that action is suppressed (`rec_level` stays low for the whole hold) and the warning is started.
- R10: The warning drives `led_warn` for WARN_MS. It is lit for the first half period of a BLINK_HZ blink and then alternates every half period. It is low after reset and after the window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_raw | input | 8 | Raw keys: 0 record, 1 level-play, 2 edge-play, 3 stop, 4 erase, 5 forward, 6 backward, 7 reset |
| core_state | input | 2 | Core activity: 0 idle, 1 recording, 2 playing, 3 erasing |
| batt_low | input | 1 | High when the supply is at or below the warning threshold |
| rec_level | output | 1 | Record request level |
| lplay_level | output | 1 | Level-play request level |
| eplay_stb | output | 1 | Edge-play command strobe |
| stop_stb | output | 1 | Stop command strobe |
| erase_stb | output | 1 | Erase-current-segment strobe |
| fwd_stb | output | 1 | Step forward one segment |
| fwd_long_stb | output | 1 | Jump to last segment |
| bwd_stb | output | 1 | Step back one segment |
| bwd_long_stb | output | 1 | Jump to first segment |
| init_stb | output | 1 | Initialise request |
| chip_erase_stb | output | 1 | Erase-all request |
| led_warn | output | 1 | Blinking warning request for the LED |

## Verification
The assertions assume that `core_state` and `batt_low` are synchronous to `clk` and may change on any cycle. They also assume that a key can bounce at any rate, because every key passes through a two-stage synchroniser first. The bench changes inputs one clock-time after a rising edge, never at the edge itself. It holds each key for a whole number of cycles, well away from the debounce and long-press thresholds, so every press falls clearly on one side of each boundary. Each key is released and allowed to settle before the next one is pressed, so the expected strobes arrive in a known order.

// File: rtl/keycond_pkg.sv
package keycond_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REC   = 2'd1,
    ST_PLAY  = 2'd2,
    ST_ERASE = 2'd3
  } core_state_e;

  localparam int K_REC   = 0;
  localparam int K_LPLAY = 1;
  localparam int K_EPLAY = 2;
  localparam int K_STOP  = 3;
  localparam int K_ERASE = 4;
  localparam int K_FWD   = 5;
  localparam int K_BWD   = 6;
  localparam int K_RST   = 7;
  localparam int NKEYS   = 8;

  // Convert a millisecond duration to a clock-cycle count (at least 2).
  function automatic int ms_to_cycles(input longint hz, input longint ms);
    longint c;
    c = (hz * ms) / 1000;
    if (c < 2) c = 2;
    return int'(c);
  endfunction

  // Half period of a blink in cycles.
  function automatic int half_period(input longint hz, input longint blink_hz);
    longint c;
    c = hz / (2 * blink_hz);
    if (c < 1) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/key_debounce.sv
module key_debounce #(
  parameter int DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; level <= 1'b0;
      rise <= 1'b0; fall <= 1'b0; cnt <= '0;
    end else begin
      s1   <= raw;
      s2   <= s1;
      rise <= 1'b0;
      fall <= 1'b0;
      if (s2 != level) begin
        if (cnt == LAST) begin
          level <= s2;
          cnt   <= '0;
          rise  <= s2;
          fall  <= !s2;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // R1
  accept_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ($past(cnt) == LAST));
  // R1
  rise_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (level && !$past(level)));
endmodule

// File: rtl/press_timer.sv
module press_timer #(
  parameter int LONG_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic fall,
  output logic short_stb,
  output logic long_stb
);
  localparam int HW = $clog2(LONG_CYC + 1);
  localparam logic [HW-1:0] LIMIT = HW'(LONG_CYC);

  logic [HW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              held <= '0;
    else if (!level)         held <= '0;
    else if (held != LIMIT)  held <= held + 1'b1;
  end

  assign long_stb  = level && (held == LIMIT - 1'b1);
  assign short_stb = fall && (held != LIMIT);

  // R5
  long_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_stb |=> !long_stb);
  // R5
  long_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_stb |-> level);
  // R4
  short_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_stb |-> ($past(level) && !level && !long_stb));
endmodule

// File: rtl/warn_blinker.sv
module warn_blinker #(
  parameter int WIN_CYC  = 2000,
  parameter int HALF_CYC = 166
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic led
);
  localparam int RW = $clog2(WIN_CYC + 1);
  localparam int PW = $clog2(HALF_CYC + 1);

  logic [RW-1:0] remain;
  logic [PW-1:0] phase;
  logic          lamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0; phase <= '0; lamp <= 1'b0;
    end else if (trig) begin
      remain <= RW'(WIN_CYC);
      phase  <= '0;
      lamp   <= 1'b1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
      if (phase == PW'(HALF_CYC - 1)) begin
        phase <= '0;
        lamp  <= !lamp;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign led = (remain != '0) && lamp;

  // R10
  warn_starts_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> led);
endmodule

// File: rtl/key_cmd_conditioner.sv
module key_cmd_conditioner
  import keycond_pkg::*;
#(
  parameter int CLK_HZ      = 768000,
  parameter int DEB_MS      = 32,
  parameter int FB_LONG_MS  = 1000,
  parameter int RST_LONG_MS = 2000,
  parameter int WARN_MS     = 2000,
  parameter int BLINK_HZ    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] key_raw,
  input  logic [1:0] core_state,
  input  logic       batt_low,
  output logic       rec_level,
  output logic       lplay_level,
  output logic       eplay_stb,
  output logic       stop_stb,
  output logic       erase_stb,
  output logic       fwd_stb,
  output logic       fwd_long_stb,
  output logic       bwd_stb,
  output logic       bwd_long_stb,
  output logic       init_stb,
  output logic       chip_erase_stb,
  output logic       led_warn
);
  localparam int DEB_CYC  = ms_to_cycles(CLK_HZ, DEB_MS);
  localparam int FB_CYC   = ms_to_cycles(CLK_HZ, FB_LONG_MS);
  localparam int RST_CYC  = ms_to_cycles(CLK_HZ, RST_LONG_MS);
  localparam int WARN_CYC = ms_to_cycles(CLK_HZ, WARN_MS);
  localparam int HALF_CYC = half_period(CLK_HZ, BLINK_HZ);

  logic [NKEYS-1:0] lvl, rise, fall;

  for (genvar k = 0; k < NKEYS; k++) begin : g_deb
    key_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
      .clk(clk), .rst_n(rst_n), .raw(key_raw[k]),
      .level(lvl[k]), .rise(rise[k]), .fall(fall[k]));
  end

  // Timed keys: forward, backward, reset
  logic [2:0] t_short, t_long;
  for (genvar t = 0; t < 3; t++) begin : g_timed
    localparam int KI  = K_FWD + t;
    localparam int LIM = (KI == K_RST) ? RST_CYC : FB_CYC;
    press_timer #(.LONG_CYC(LIM)) u_tmr (
      .clk(clk), .rst_n(rst_n), .level(lvl[KI]), .fall(fall[KI]),
      .short_stb(t_short[t]), .long_stb(t_long[t]));
  end

  core_state_e st;
  assign st = core_state_e'(core_state);

  logic erasing, playing;
  assign erasing = (st == ST_ERASE);
  assign playing = (st == ST_PLAY);

  // Record acceptance is decided once per press, at the debounced rising edge.
  logic rec_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rec_ok <= 1'b0;
    else if (rise[K_REC])    rec_ok <= !batt_low && !erasing;
    else if (fall[K_REC])    rec_ok <= 1'b0;
  end

  logic rec_now;
  assign rec_now = rise[K_REC] && !batt_low && !erasing;

  // Named intermediate events for the checks
  logic erase_req, rst_req, warn_trig;
  assign erase_req = rise[K_ERASE] && !erasing;
  assign rst_req   = t_short[2] || t_long[2];
  assign warn_trig = batt_low &&
                     ((rise[K_REC] && !erasing) || erase_req || rst_req);

  assign rec_level      = lvl[K_REC] && (rec_ok || rec_now) && !erasing;
  assign lplay_level    = lvl[K_LPLAY] && !erasing;
  assign eplay_stb      = rise[K_EPLAY] && !erasing;
  assign stop_stb       = rise[K_STOP] && playing;
  assign erase_stb      = erase_req && !batt_low;
  assign fwd_stb        = t_short[0] && !erasing;
  assign fwd_long_stb   = t_long[0] && !erasing;
  assign bwd_stb        = t_short[1] && !erasing;
  assign bwd_long_stb   = t_long[1] && !erasing;
  assign init_stb       = t_short[2] && !batt_low;
  assign chip_erase_stb = t_long[2] && !batt_low;

  warn_blinker #(.WIN_CYC(WARN_CYC), .HALF_CYC(HALF_CYC)) u_warn (
    .clk(clk), .rst_n(rst_n), .trig(warn_trig), .led(led_warn));

  logic unused_edges;
  assign unused_edges = ^{fall[K_ERASE:K_LPLAY], rise[K_RST:K_FWD], rise[K_LPLAY]};

  // R8
  erase_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erasing |-> !(eplay_stb || stop_stb || erase_stb || fwd_stb || fwd_long_stb ||
                  bwd_stb || bwd_long_stb || rec_level || lplay_level));
  // R7
  stop_only_playing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |-> (core_state == 2'd2));
  // R9
  low_batt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_low |-> !(erase_stb || init_stb || chip_erase_stb || $rose(rec_level)));
  // R6
  reset_single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_stb && chip_erase_stb));
endmodule

// File: tb/tb_key_cmd_conditioner.sv
module tb_key_cmd_conditioner;
  localparam int CLK_HZ = 1000;
  localparam int DEB    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] key_raw = '0;
  logic [1:0] core_state = 2'd0;
  logic       batt_low = 1'b0;
  logic rec_level, lplay_level, eplay_stb, stop_stb, erase_stb, fwd_stb, fwd_long_stb;
  logic bwd_stb, bwd_long_stb, init_stb, chip_erase_stb, led_warn;

  always #5 clk = ~clk;

  key_cmd_conditioner #(.CLK_HZ(CLK_HZ), .DEB_MS(4), .FB_LONG_MS(1000),
    .RST_LONG_MS(2000), .WARN_MS(2000), .BLINK_HZ(3)) dut (
    .clk(clk), .rst_n(rst_n), .key_raw(key_raw), .core_state(core_state),
    .batt_low(batt_low), .rec_level(rec_level), .lplay_level(lplay_level),
    .eplay_stb(eplay_stb), .stop_stb(stop_stb), .erase_stb(erase_stb),
    .fwd_stb(fwd_stb), .fwd_long_stb(fwd_long_stb), .bwd_stb(bwd_stb),
    .bwd_long_stb(bwd_long_stb), .init_stb(init_stb),
    .chip_erase_stb(chip_erase_stb), .led_warn(led_warn));

  // Strobe codes: 0 eplay,1 stop,2 erase,3 fwd,4 fwd_long,5 bwd,6 bwd_long,7 init,8 chip
  logic [8:0] stb;
  assign stb = {chip_erase_stb, init_stb, bwd_long_stb, bwd_stb, fwd_long_stb,
                fwd_stb, erase_stb, stop_stb, eplay_stb};

  int    compared = 0, mismatched = 0, seen = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    done = 1'b0;

  task automatic expect_stb(input int code, input string tag);
    exp_q.push_back(code);
    tag_q.push_back(tag);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected strobes as the design produces them
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 9; i++) begin
        if (stb[i]) begin
          seen++;
          compared++;
          if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL unexpected strobe: actual code %0d expected none", i);
          end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e != i) begin
              mismatched++;
              $display("FAIL %s: actual code %0d expected %0d", t, i, e);
            end
          end
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic press(input int idx, input int hold);
    cyc(1);
    key_raw[idx] = 1'b1;
    cyc(hold);
    key_raw[idx] = 1'b0;
    cyc(DEB + 30);
  endtask

  task automatic drain(input string tag);
    check(tag, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int s0;
    int t;
    cyc(5);
    // R10 / R2: reset state
    check("R10 led after reset", led_warn, 0);
    check("R2 rec after reset", rec_level, 0);
    rst_n = 1'b1;
    cyc(5);
    check("R2 lplay idle", lplay_level, 0);

    // R1: glitch shorter than debounce window
    s0 = seen;
    cyc(1); key_raw[2] = 1'b1; cyc(2); key_raw[2] = 1'b0; cyc(30);
    check("R1 glitch ignored", seen, s0);

    // R3: edge-play strobe
    expect_stb(0, "R3 eplay"); press(2, 40); drain("R3 eplay");

    // R2: record level while held
    cyc(1); key_raw[0] = 1'b1; cyc(DEB + 10);
    check("R2 rec held", rec_level, 1);
    key_raw[0] = 1'b0; cyc(DEB + 10);
    check("R2 rec released", rec_level, 0);
    cyc(1); key_raw[1] = 1'b1; cyc(DEB + 10);
    check("R2 lplay held", lplay_level, 1);
    key_raw[1] = 1'b0; cyc(DEB + 10);
    check("R2 lplay released", lplay_level, 0);

    // R4: short forward/backward
    expect_stb(3, "R4 fwd short"); press(5, 300);
    expect_stb(5, "R4 bwd short"); press(6, 300); drain("R4 short");

    // R5: long forward/backward
    expect_stb(4, "R5 fwd long"); press(5, 1200);
    expect_stb(6, "R5 bwd long"); press(6, 1200); drain("R5 long");

    // R7: stop honoured only while playing
    s0 = seen; press(3, 40);
    check("R7 stop idle ignored", seen, s0);
    core_state = 2'd1; s0 = seen; press(3, 40);
    check("R7 stop recording ignored", seen, s0);
    core_state = 2'd2; expect_stb(1, "R7 stop playing"); press(3, 40);
    core_state = 2'd0; drain("R7 stop");

    // R3: erase; R6: reset short and long
    expect_stb(2, "R3 erase"); press(4, 40);
    expect_stb(7, "R6 init"); press(7, 100);
    expect_stb(8, "R6 chip erase"); press(7, 2200); drain("R6 reset");

    // R8: erasing locks out all keys but reset
    core_state = 2'd3; s0 = seen;
    press(2, 40); press(4, 40); press(5, 300); press(6, 1200);
    cyc(1); key_raw[0] = 1'b1; key_raw[1] = 1'b1; cyc(DEB + 10);
    check("R8 rec locked", rec_level, 0);
    check("R8 lplay locked", lplay_level, 0);
    key_raw[0] = 1'b0; key_raw[1] = 1'b0; cyc(DEB + 10);
    check("R8 strobes locked", seen, s0);
    expect_stb(7, "R8 reset allowed"); press(7, 100);
    core_state = 2'd0; drain("R8 reset");

    // R9: low battery blocks erase and starts warning
    batt_low = 1'b1; s0 = seen;
    cyc(1); key_raw[4] = 1'b1; cyc(20); key_raw[4] = 1'b0;
    t = 0;
    while (!led_warn && t < 100) begin @(negedge clk); t++; end
    check("R9 warning started", led_warn, 1);
    repeat (80)   @(negedge clk); check("R10 first half lit", led_warn, 1);
    repeat (170)  @(negedge clk); check("R10 second half dark", led_warn, 0);
    repeat (150)  @(negedge clk); check("R10 third half lit", led_warn, 1);
    repeat (1700) @(negedge clk); check("R10 window ended", led_warn, 0);
    check("R9 erase suppressed", seen, s0);

    // R9: record and reset blocked under low battery
    cyc(1); key_raw[0] = 1'b1; cyc(DEB + 10);
    check("R9 rec blocked", rec_level, 0);
    batt_low = 1'b0; cyc(20);
    check("R9 rec stays blocked for hold", rec_level, 0);
    key_raw[0] = 1'b0; cyc(DEB + 10);
    batt_low = 1'b1; s0 = seen; press(7, 100);
    check("R9 init suppressed", seen, s0);
    check("R9 reset warns", led_warn, 1);
    batt_low = 1'b0;
    cyc(20);
    drain("R9 end");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule